// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor core that retires one instruction in every clock cycle. On each cycle it presents the program counter to an external instruction memory and takes back a 32-bit instruction word. It splits the word into fixed fields and reads two operands from a 32-entry register file. It then computes a result in the ALU, drives an external data memory for loads and stores, and commits the register write and the new program counter on the next rising clock edge.

The instruction set is deliberately narrow. It has five register-to-register operations (add, subtract, and, or, signed set-if-less), word load, word store, branch when two registers are equal, and an absolute jump within the current 256 MB region. Both memories sit outside the core and answer combinationally within the same cycle. The core contains the next-address logic, the control decoder, the operand, write-back and next-address selectors, immediate sign extension and the two target adders.

Reset is asserted asynchronously on `rst_n` low and is released through a two-stage synchroniser. The core therefore fetches from address 0 for a short while before the first instruction commits.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, and until the synchronised release has propagated, `imem_addr` is 0 and no data-memory write, data-memory read or register write is issued. Execution starts at address 0.
- R2: After a register-to-register instruction (opcode 000000), a load (100011), a store (101011) or an unrecognised opcode, the next fetch address is the current address plus 4.
- R3: A register-to-register instruction reads its sources from bits [25:21] and [20:16] and writes its result to the register named by bits [15:11]. Bits [5:0] select the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 signed set-if-less (result 1 or 0).
- R4: A load drives `dmem_addr` with the register named by [25:21] plus the sign-extended bits [15:0]. It asserts `dmem_re` and writes `dmem_rdata` into the register named by [20:16].
- R5: A store drives the same address and asserts `dmem_we` with the register named by [20:16] on `dmem_wdata`. It writes no register. `dmem_we` and `dmem_re` are never high together.
- R6: A branch (opcode 000100) compares the registers named by [25:21] and [20:16]. When they are equal, the next address is PC+4 plus the sign-extended [15:0] shifted left by 2. Otherwise it is PC+4. It writes neither a register nor memory.
- R7: A jump (opcode 000010) sets the next address to bits [31:28] of PC+4, followed by bits [25:0] of the instruction, followed by two zero bits.
- R8: Register 0 always reads as 0. A write that targets it has no effect.
- R9: An unrecognised opcode writes no register and no memory.
- R10: A register written by one instruction holds the new value for the instruction in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr | output | 32 | Fetch address (current program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data-memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data |
| dmem_re | output | 1 | Load in progress this cycle |
| dmem_we | output | 1 | Store in progress; memory writes on the next rising edge |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, same cycle |

## Verification
The bench runs an instruction-level model in lockstep with the core. Each cycle it compares the fetch address, the memory strobes, the address and the store data. Register contents show up through later stores, so a lost register write or a wrong forwarding of a just-written value appears as wrong store data one or more instructions later. Directed cases target the following errors:
- a write to register 0 that sticks, which would store a non-zero value from it;
- a set-if-less that compares unsigned, which would give 0 for a negative first operand;
- a branch that ignores the equality flag, which would skip an instruction it should execute;
- a jump built from the wrong upper bits or without the shift, which would land at a wrong address;
- an unknown opcode that leaks a write enable, which would corrupt a register or memory word.

Random code then mixes all instruction kinds, including backward branches and jumps across the program.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    AM_MEM = 2'b00,
    AM_BR  = 2'b01,
    AM_REG = 2'b10
  } alu_mode_e;

  typedef struct packed {
    logic      dst_rd;
    logic      src_imm;
    logic      wb_mem;
    logic      reg_we;
    logic      mem_re;
    logic      mem_we;
    logic      branch;
    logic      jump;
    alu_mode_e alu_mode;
  } ctrl_t;

endpackage

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_fn_e         fn,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  always_comb begin
    case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);

  logic [XLEN-1:0] q [DEPTH];

  // entry 0 is never written; each other entry has its own enable
  always_ff @(posedge clk) begin
    for (int i = 1; i < DEPTH; i++) begin
      if (we && (waddr == AW'(i))) begin
        q[i] <= wdata;
      end
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : q[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : q[raddr_b];

endmodule

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_fn_e    alu_fn
);

  always_comb begin
    ctrl          = '0;
    ctrl.alu_mode = AM_MEM;
    case (opcode)
      OPC_REG: begin
        ctrl.dst_rd   = 1'b1;
        ctrl.reg_we   = 1'b1;
        ctrl.alu_mode = AM_REG;
      end
      OPC_LOAD: begin
        ctrl.src_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.mem_re  = 1'b1;
      end
      OPC_STORE: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch   = 1'b1;
        ctrl.alu_mode = AM_BR;
      end
      OPC_JUMP: begin
        ctrl.jump = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (ctrl.alu_mode)
      AM_BR:  alu_fn = ALU_SUB;
      AM_REG: begin
        case (funct)
          FN_SUB:  alu_fn = ALU_SUB;
          FN_AND:  alu_fn = ALU_AND;
          FN_OR:   alu_fn = ALU_OR;
          FN_SLT:  alu_fn = ALU_SLT;
          default: alu_fn = ALU_ADD;
        endcase
      end
      default: alu_fn = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_pc_unit.sv
module sc_pc_unit #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JIDX_W-1:0] jidx,
  input  logic              branch,
  input  logic              jump,
  input  logic              zero,
  output logic [XLEN-1:0]   pc
);

  localparam int STEP = 4;

  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] br_off;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jmp_tgt;
  logic [XLEN-1:0] pc_d;

  always_comb begin
    pc_plus4 = pc + XLEN'(STEP);
    br_off   = {{(XLEN-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
    br_tgt   = pc_plus4 + br_off;
    jmp_tgt  = {pc_plus4[XLEN-1:JIDX_W+2], jidx, 2'b00};
    if (jump) begin
      pc_d = jmp_tgt;
    end else if (branch && zero) begin
      pc_d = br_tgt;
    end else begin
      pc_d = pc_plus4;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else begin
      pc <= pc_d;
    end
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int NREG        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_re,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int RAW    = $clog2(NREG);
  localparam int IMM_W  = 16;
  localparam int JIDX_W = 26;

  // reset: asynchronous assertion, synchronous release
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign run_q = sync_q[SYNC_STAGES-1];

  // field split
  logic [5:0]        f_op;
  logic [RAW-1:0]    f_rs;
  logic [RAW-1:0]    f_rt;
  logic [RAW-1:0]    f_rd;
  logic [5:0]        f_fn;
  logic [IMM_W-1:0]  f_imm;
  logic [JIDX_W-1:0] f_jidx;

  assign f_op   = imem_rdata[31:26];
  assign f_rs   = imem_rdata[25:21];
  assign f_rt   = imem_rdata[20:16];
  assign f_rd   = imem_rdata[15:11];
  assign f_fn   = imem_rdata[5:0];
  assign f_imm  = imem_rdata[15:0];
  assign f_jidx = imem_rdata[25:0];

  ctrl_t   ctrl;
  alu_fn_e alu_fn;

  sc_decode u_dec (
    .opcode (f_op),
    .funct  (f_fn),
    .ctrl   (ctrl),
    .alu_fn (alu_fn)
  );

  logic            rf_we;
  logic [RAW-1:0]  rf_waddr;
  logic [XLEN-1:0] rf_wdata;
  logic [XLEN-1:0] rd_a;
  logic [XLEN-1:0] rd_b;

  sc_regfile #(.XLEN(XLEN), .DEPTH(NREG)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (f_rs),
    .raddr_b (f_rt),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] alu_y;
  logic            alu_zero;

  assign imm_ext = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
  assign opnd_b  = ctrl.src_imm ? imm_ext : rd_b;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .a    (rd_a),
    .b    (opnd_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // write-back and memory side, enables held off until release
  assign rf_we      = ctrl.reg_we & run_q;
  assign rf_waddr   = ctrl.dst_rd ? f_rd : f_rt;
  assign rf_wdata   = ctrl.wb_mem ? dmem_rdata : alu_y;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rd_b;
  assign dmem_we    = ctrl.mem_we & run_q;
  assign dmem_re    = ctrl.mem_re & run_q;

  sc_pc_unit #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_pc (
    .clk    (clk),
    .rst_n  (run_q),
    .imm    (f_imm),
    .jidx   (f_jidx),
    .branch (ctrl.branch),
    .jump   (ctrl.jump),
    .zero   (alu_zero),
    .pc     (imem_addr)
  );

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_core_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        dmem_we,
  input logic        dmem_re,
  input logic        reg_we
);

  logic [5:0] op;
  logic       known;

  assign op    = instr[31:26];
  assign known = (op == OPC_REG) || (op == OPC_LOAD) || (op == OPC_STORE) ||
                 (op == OPC_BEQ) || (op == OPC_JUMP);

  // R1
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pc == 32'd0));

  // R1
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!dmem_we && !dmem_re && !reg_we));

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op != OPC_BEQ && op != OPC_JUMP) |=> (pc == $past(pc) + 32'd4));

  // R7
  jump_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == OPC_JUMP) |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));

  // R5
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));

  // R4
  load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |-> (op == OPC_LOAD));

  // R9
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !known) |-> (!reg_we && !dmem_we));

endmodule

bind sc_core sc_core_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run_q),
  .pc      (imem_addr),
  .instr   (imem_rdata),
  .dmem_we (dmem_we),
  .dmem_re (dmem_re),
  .reg_we  (rf_we)
);

// File: tb/sc_core_test.sv
module sc_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int IM_WORDS   = 256;
  localparam int DM_WORDS   = 64;
  localparam int NCYC       = 4000;

  logic        clk;
  logic        rst_n;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata;
  logic [31:0] dmem_addr;
  logic [31:0] dmem_wdata;
  logic        dmem_re;
  logic        dmem_we;
  logic [31:0] dmem_rdata;

  logic [31:0] imem [IM_WORDS];
  logic [31:0] dmem [DM_WORDS];

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  sc_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_re    (dmem_re),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  // instruction-level model
  logic [31:0] m_pc;
  logic [31:0] m_reg [32];
  logic [31:0] m_dm  [DM_WORDS];
  int          m_wk  [32];
  logic [4:0]  m_last;
  bit          m_last_ok;
  string       pc_tag;

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                        logic [4:0] rd, logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                        logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [25:0] idx);
    return {6'b000010, idx};
  endfunction

  function automatic logic [31:0] alu_ref(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      6'b100010: return a - b;
      6'b100100: return a & b;
      6'b100101: return a | b;
      6'b101010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default:   return a + b;
    endcase
  endfunction

  function automatic logic [31:0] rand_instr();
    logic [5:0] fns [5] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
    logic [5:0] bad [4] = '{6'b111111, 6'b001000, 6'b000011, 6'b110000};
    int unsigned k = $urandom % 16;
    logic [4:0] ra = 5'($urandom % 32);
    logic [4:0] rb = 5'($urandom % 32);
    logic [4:0] rc = 5'($urandom % 32);
    int off;
    if (k < 6 || k > 13) return enc_r(ra, rb, rc, fns[$urandom % 5]);
    if (k < 8)  return enc_i(6'b100011, 5'd0, rb, 16'(4 * ($urandom % 64)));
    if (k < 10) return enc_i(6'b101011, 5'd0, rb, 16'(4 * ($urandom % 64)));
    if (k < 12) begin
      off = int'($urandom % 13) - 6;
      if (off == -1) off = 2;
      return enc_i(6'b000100, ra, ($urandom % 2 == 0) ? ra : rb, off[15:0]);
    end
    if (k == 12) return enc_j(26'($urandom % 256));
    return {bad[$urandom % 4], 26'($urandom)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rreg(logic [4:0] r);
    return (r == 5'd0) ? 32'd0 : m_reg[r];
  endfunction

  task automatic step_check();
    logic [31:0] ins = imem[m_pc[9:2]];
    logic [5:0]  op  = ins[31:26];
    logic [4:0]  rs  = ins[25:21];
    logic [4:0]  rt  = ins[20:16];
    logic [4:0]  rd  = ins[15:11];
    logic [31:0] sx  = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] a   = rreg(rs);
    logic [31:0] b   = rreg(rt);
    logic [31:0] p4  = m_pc + 32'd4;
    logic [31:0] nx  = p4;
    logic [31:0] ea  = a + sx;
    string       st;
    bit          wrote = 0;
    chk(imem_addr == m_pc, pc_tag, "fetch address", imem_addr, m_pc);
    case (op)
      6'b000000: begin
        chk(!dmem_we && !dmem_re, "R3", "mem strobes on reg op", {30'd0, dmem_we, dmem_re}, 32'd0);
        if (rd != 5'd0) begin
          m_reg[rd] = alu_ref(ins[5:0], a, b); m_wk[rd] = 1; m_last = rd; wrote = 1;
        end
        pc_tag = "R2";
      end
      6'b100011: begin
        chk(dmem_re && !dmem_we, "R4", "load strobes", {30'd0, dmem_we, dmem_re}, 32'd1);
        chk(dmem_addr == ea, "R4", "load address", dmem_addr, ea);
        if (rt != 5'd0) begin
          m_reg[rt] = m_dm[ea[7:2]]; m_wk[rt] = 2; m_last = rt; wrote = 1;
        end
        pc_tag = "R2";
      end
      6'b101011: begin
        if (rt == 5'd0) st = "R8";
        else if (m_last_ok && m_last == rt) st = "R10";
        else if (m_wk[rt] == 1) st = "R3";
        else st = "R4";
        chk(dmem_we && !dmem_re, "R5", "store strobes", {30'd0, dmem_we, dmem_re}, 32'd2);
        chk(dmem_addr == ea, "R5", "store address", dmem_addr, ea);
        chk(dmem_wdata == b, st, "store data", dmem_wdata, b);
        m_dm[ea[7:2]] = b;
        pc_tag = "R2";
      end
      6'b000100: begin
        chk(!dmem_we && !dmem_re, "R6", "mem strobes on branch", {30'd0, dmem_we, dmem_re}, 32'd0);
        if (a == b) nx = p4 + {sx[29:0], 2'b00};
        pc_tag = "R6";
      end
      6'b000010: begin
        chk(!dmem_we && !dmem_re, "R7", "mem strobes on jump", {30'd0, dmem_we, dmem_re}, 32'd0);
        nx = {p4[31:28], ins[25:0], 2'b00};
        pc_tag = "R7";
      end
      default: begin
        chk(!dmem_we && !dmem_re, "R9", "mem strobes on unknown op", {30'd0, dmem_we, dmem_re}, 32'd0);
        pc_tag = "R9";
      end
    endcase
    m_last_ok = wrote;
    m_pc = nx;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240613);
    for (int i = 0; i < DM_WORDS; i++) dmem[i] = $urandom;
    dmem[1] = 32'h8000_0000;
    dmem[2] = 32'd5;
    for (int i = 0; i < DM_WORDS; i++) m_dm[i] = dmem[i];
    for (int i = 0; i < 32; i++) begin m_reg[i] = 32'd0; m_wk[i] = 0; end
    // prologue: load every register from data memory
    for (int i = 1; i < 32; i++) imem[i-1] = enc_i(6'b100011, 5'd0, 5'(i), 16'(4 * i));
    // directed corner cases
    imem[31] = enc_r(5'd1, 5'd2, 5'd0, 6'b100000);   // R8: write to r0
    imem[32] = enc_i(6'b101011, 5'd0, 5'd0, 16'd0);
    imem[33] = enc_r(5'd1, 5'd2, 5'd3, 6'b100010);   // R10: back-to-back use
    imem[34] = enc_i(6'b101011, 5'd0, 5'd3, 16'd4);
    imem[35] = enc_r(5'd1, 5'd2, 5'd5, 6'b101010);   // R3: signed compare
    imem[36] = enc_i(6'b101011, 5'd0, 5'd5, 16'd8);
    imem[37] = enc_i(6'b000100, 5'd1, 5'd1, 16'd1);  // R6: taken, skips 38
    imem[38] = enc_i(6'b101011, 5'd0, 5'd1, 16'd12);
    imem[39] = {6'b111111, 5'd1, 5'd1, 16'hFFFF};    // R9: unknown opcode
    imem[40] = enc_i(6'b000100, 5'd1, 5'd2, 16'd5);  // R6: not taken
    imem[41] = enc_r(5'd1, 5'd2, 5'd6, 6'b100100);
    imem[42] = enc_r(5'd1, 5'd2, 5'd7, 6'b100101);
    imem[43] = enc_j(26'd45);                        // R7: skips 44
    imem[44] = enc_i(6'b101011, 5'd0, 5'd1, 16'd16);
    for (int i = 45; i < IM_WORDS; i++) imem[i] = rand_instr();

    m_pc = 32'd0; m_last = 5'd0; m_last_ok = 0; pc_tag = "R1";
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(imem_addr == 32'd0, "R1", "fetch address in reset", imem_addr, 32'd0);
      chk(!dmem_we && !dmem_re, "R1", "mem strobes in reset", {30'd0, dmem_we, dmem_re}, 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(imem_addr == 32'd0, "R1", "fetch address during release", imem_addr, 32'd0);
    chk(!dmem_we && !dmem_re, "R1", "mem strobes during release", {30'd0, dmem_we, dmem_re}, 32'd0);
    @(negedge clk);
    for (int c = 0; c < NCYC; c++) begin
      step_check();
      @(negedge clk);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'd0, 32'd1);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule